// File: doc/BRIEF.md
# I2C memory transaction sequencer

This block runs whole I2C memory transactions on top of a byte-level bus engine. The engine knows only four commands: START, STOP, write one byte (returning the acknowledge bit seen on the bus), and read one byte (sending a chosen acknowledge bit). The sequencer turns one accepted request into the right string of these commands. A request is a probe (address the device and check whether it answers), a write (device address, 0 to 4 memory-address bytes, then N data bytes), or a read (set the memory pointer, then fetch N bytes).

Data to write arrives on a valid/ready byte stream, and read data leaves on another one. When the read consumer is slow, the sequencer waits before it asks the engine for the next byte, so no byte is ever lost. The result (device answered, memory-address error, count of data bytes the device refused) is valid for the single cycle in which `done` is high. Between the pointer write and the read, the sequencer sends either a repeated START or a STOP followed by a START; an input selects which. Address bits above the chosen address length can be folded into the device address through a mask, for memories that take their upper address bits in the device-address slot.

Top module: `i2c_mem_seq`

## Requirements
- R1: The device address byte is the 7-bit device address in bits 7..1, with bit 0 equal to 0 for the write direction and 1 for the read direction.
- R2: A probe (cmd_op 0; the unused code 3 behaves the same) issues START, the write-direction address byte, then STOP; res_present is 1 exactly when that byte was acknowledged, and res_err and res_fails are 0.
- R3: In a write (cmd_op 1), the cmd_alen memory-address bytes (0 to 4) follow the device byte, the most significant byte first; byte i is cmd_maddr[8i+7:8i].
- R4: If the write-direction device byte is not acknowledged (in a write, or in a read with cmd_alen above 0), STOP follows at once, no other byte is sent, and res_present is 0.
- R5: If a memory-address byte is not acknowledged, STOP follows at once and the result has res_err 1 and res_present 1.
- R6: In a read (cmd_op 2) with cmd_alen above 0, the last memory-address byte is followed by STOP then START when cfg_rep_start is 0, and by START alone when it is 1, and then by the read-direction device byte.
- R7: In a read with cmd_alen 0, START is followed directly by the read-direction device byte.
- R8: After an acknowledged read-direction device byte, cmd_len bytes are read, each asking for ACK (eng_last 0) except the last, which asks for NACK (eng_last 1), and STOP follows; a refused read-direction device byte gives STOP at once and res_present 0.
- R9: In a write, a refused data byte does not stop the transfer; every data byte is still sent, then STOP, and res_fails equals the number of refused data bytes.
- R10: The device address used is cmd_dev OR ((cmd_maddr shifted right by 8*cmd_alen) AND cfg_ovf_mask) on the low 7 bits; a zero mask leaves cmd_dev unchanged.
- R11: A request is taken when cmd_valid and cmd_ready are both 1; cmd_ready is 0 and busy is 1 from the next cycle until the final STOP completes; done is a one-cycle pulse, with busy already 0, carrying the result.
- R12: Read bytes are delivered on rd_data in bus order; rd_valid with rd_data stays unchanged until rd_ready, and no engine command is pending while a read byte waits.
- R13: Each write data byte is taken from the wr stream exactly once, in order, and no data WRITE command is issued before its byte is available.
- R14: Engine op codes are 0 START, 1 STOP, 2 WRITE, 3 READ; a command stays on eng_valid, eng_op and eng_wbyte unchanged until the cycle with eng_done, and only one is pending at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Request offered |
| cmd_ready | output | 1 | Sequencer idle, request can be taken |
| cmd_op | input | 2 | 0 probe, 1 write, 2 read |
| cmd_dev | input | 7 | 7-bit device address |
| cmd_maddr | input | 8*(MAX_ALEN+1) | Memory address, plus overflow bits above the used bytes |
| cmd_alen | input | clog2(MAX_ALEN+1) | Number of memory-address bytes, 0 to MAX_ALEN |
| cmd_len | input | LEN_W | Number of data bytes |
| cfg_rep_start | input | 1 | 1: repeated START before read phase; 0: STOP then START |
| cfg_ovf_mask | input | 7 | Mask of overflow bits folded into the device address |
| wr_valid | input | 1 | Write data byte offered |
| wr_ready | output | 1 | Write data byte taken this cycle |
| wr_data | input | 8 | Write data byte |
| rd_valid | output | 1 | Read data byte available |
| rd_ready | input | 1 | Consumer takes the read byte |
| rd_data | output | 8 | Read data byte |
| eng_valid | output | 1 | Command pending to the byte engine |
| eng_op | output | 2 | Engine command code |
| eng_wbyte | output | 8 | Byte to write |
| eng_last | output | 1 | For READ: send NACK after this byte |
| eng_done | input | 1 | Engine finished the pending command |
| eng_nack | input | 1 | For WRITE: the byte was not acknowledged |
| eng_rbyte | input | 8 | For READ: byte received |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| res_present | output | 1 | Device acknowledged its address |
| res_err | output | 1 | A memory-address byte was refused |
| res_fails | output | LEN_W | Count of refused write data bytes |

## Verification
The bench builds the block with MAX_ALEN 4 and LEN_W 8, so every address length from 0 to 4 and the case where the overflow field begins right above a full 4-byte address are both reachable. With transfers kept up to 16 bytes the fail counter stays far from wrapping, and a behavioural engine with random latency and a per-transaction acknowledge pattern reaches each abort point. Random stalls on both data streams exercise the read holding register and the write gating.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [1:0] {
    ENG_START = 2'd0,
    ENG_STOP  = 2'd1,
    ENG_WRITE = 2'd2,
    ENG_READ  = 2'd3
  } eng_op_e;

  typedef enum logic [1:0] {
    OP_PROBE = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } txn_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_START1, S_DEVW, S_MADDR, S_WDATA,
    S_STOPM, S_START2, S_DEVR, S_RDATA, S_RHOLD, S_STOPE
  } seq_state_e;
endpackage

// File: rtl/i2cs_dev_fold.sv
module i2cs_dev_fold #(
  parameter int MAX_ALEN = 4,
  localparam int AL_W = $clog2(MAX_ALEN + 1),
  localparam int MA_W = 8 * (MAX_ALEN + 1)
) (
  input  logic [6:0]      dev,
  input  logic [MA_W-1:0] maddr,
  input  logic [AL_W-1:0] alen,
  input  logic [6:0]      mask,
  output logic [6:0]      dev_eff
);
  logic [MA_W-1:0] upper;

  always_comb begin
    upper   = maddr >> {alen, 3'b000};
    dev_eff = dev | (upper[6:0] & mask);
  end
endmodule

// File: rtl/i2cs_fail_cnt.sv
module i2cs_fail_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (inc)   count <= count + 1'b1;
  end
endmodule

// File: rtl/i2cs_seq.sv
module i2cs_seq
  import i2cs_pkg::*;
#(
  parameter int MAX_ALEN = 4,
  parameter int LEN_W    = 8,
  localparam int AL_W = $clog2(MAX_ALEN + 1),
  localparam int MA_W = 8 * (MAX_ALEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [6:0]       dev_eff,
  input  logic [MA_W-1:0]  cmd_maddr,
  input  logic [AL_W-1:0]  cmd_alen,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             cfg_rep_start,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             eng_valid,
  output logic [1:0]       eng_op,
  output logic [7:0]       eng_wbyte,
  output logic             eng_last,
  input  logic             eng_done,
  input  logic             eng_nack,
  input  logic [7:0]       eng_rbyte,
  output logic             busy,
  output logic             done,
  output logic             res_present,
  output logic             res_err,
  output logic             fail_clr,
  output logic             fail_inc
);
  seq_state_e       state;
  logic [1:0]       op_q;
  logic [6:0]       dev_q;
  logic [MA_W-1:0]  maddr_q;
  logic [AL_W-1:0]  alen_q;
  logic [AL_W-1:0]  idx_q;
  logic [LEN_W-1:0] remain_q;
  logic             rep_q;

  logic [1:0]       cur_op;
  logic [7:0]       cur_byte;
  logic [MA_W-1:0]  addr_shift;
  logic             launch_ok;
  logic             is_write, is_read, fin;

  assign is_write  = (op_q == OP_WRITE);
  assign is_read   = (op_q == OP_READ);
  assign busy      = (state != S_IDLE);
  assign cmd_ready = (state == S_IDLE);
  assign fail_clr  = cmd_valid && (state == S_IDLE);
  assign fin       = eng_valid && eng_done;
  assign fail_inc  = (state == S_WDATA) && fin && eng_nack;
  assign wr_ready  = (state == S_WDATA) && !eng_valid;
  assign launch_ok = (state != S_WDATA) || wr_valid;

  // Command that belongs to the current state
  always_comb begin
    addr_shift = maddr_q >> {idx_q, 3'b000};
    cur_op     = ENG_START;
    cur_byte   = 8'h00;
    case (state)
      S_STOPM, S_STOPE: cur_op = ENG_STOP;
      S_DEVW:  begin cur_op = ENG_WRITE; cur_byte = {dev_q, 1'b0}; end
      S_DEVR:  begin cur_op = ENG_WRITE; cur_byte = {dev_q, 1'b1}; end
      S_MADDR: begin cur_op = ENG_WRITE; cur_byte = addr_shift[7:0]; end
      S_WDATA: begin cur_op = ENG_WRITE; cur_byte = wr_data; end
      S_RDATA: cur_op = ENG_READ;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      op_q        <= OP_PROBE;
      dev_q       <= '0;
      maddr_q     <= '0;
      alen_q      <= '0;
      idx_q       <= '0;
      remain_q    <= '0;
      rep_q       <= 1'b0;
      eng_valid   <= 1'b0;
      eng_op      <= ENG_START;
      eng_wbyte   <= '0;
      eng_last    <= 1'b0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      done        <= 1'b0;
      res_present <= 1'b0;
      res_err     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == S_IDLE) begin
        if (cmd_valid) begin
          op_q        <= cmd_op;
          dev_q       <= dev_eff;
          maddr_q     <= cmd_maddr;
          alen_q      <= cmd_alen;
          remain_q    <= cmd_len;
          rep_q       <= cfg_rep_start;
          res_present <= 1'b0;
          res_err     <= 1'b0;
          state       <= S_START1;
        end
      end else if (state == S_RHOLD) begin
        if (rd_ready) begin
          rd_valid <= 1'b0;
          remain_q <= remain_q - 1'b1;
          state    <= (remain_q == 1) ? S_STOPE : S_RDATA;
        end
      end else if (!eng_valid) begin
        if (launch_ok) begin
          eng_valid <= 1'b1;
          eng_op    <= cur_op;
          eng_wbyte <= cur_byte;
          eng_last  <= (remain_q == 1);
        end
      end else if (eng_done) begin
        eng_valid <= 1'b0;
        case (state)
          S_START1: state <= (is_read && alen_q == 0) ? S_DEVR : S_DEVW;
          S_DEVW: begin
            res_present <= !eng_nack;
            if (eng_nack || !(is_write || is_read)) state <= S_STOPE;
            else if (alen_q != 0) begin
              idx_q <= alen_q - 1'b1;
              state <= S_MADDR;
            end else state <= (remain_q != 0) ? S_WDATA : S_STOPE;
          end
          S_MADDR: begin
            if (eng_nack) begin
              res_err <= 1'b1;
              state   <= S_STOPE;
            end else if (idx_q != 0) idx_q <= idx_q - 1'b1;
            else if (is_write) state <= (remain_q != 0) ? S_WDATA : S_STOPE;
            else state <= rep_q ? S_START2 : S_STOPM;
          end
          S_WDATA: begin
            remain_q <= remain_q - 1'b1;
            state    <= (remain_q == 1) ? S_STOPE : S_WDATA;
          end
          S_STOPM:  state <= S_START2;
          S_START2: state <= S_DEVR;
          S_DEVR: begin
            res_present <= !eng_nack;
            state <= (eng_nack || remain_q == 0) ? S_STOPE : S_RDATA;
          end
          S_RDATA: begin
            rd_data  <= eng_rbyte;
            rd_valid <= 1'b1;
            state    <= S_RHOLD;
          end
          default: begin
            state <= S_IDLE;
            done  <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_mem_seq.sv
module i2c_mem_seq #(
  parameter int MAX_ALEN = 4,
  parameter int LEN_W    = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cmd_valid,
  output logic                           cmd_ready,
  input  logic [1:0]                     cmd_op,
  input  logic [6:0]                     cmd_dev,
  input  logic [8*(MAX_ALEN+1)-1:0]      cmd_maddr,
  input  logic [$clog2(MAX_ALEN+1)-1:0]  cmd_alen,
  input  logic [LEN_W-1:0]               cmd_len,
  input  logic                           cfg_rep_start,
  input  logic [6:0]                     cfg_ovf_mask,
  input  logic                           wr_valid,
  output logic                           wr_ready,
  input  logic [7:0]                     wr_data,
  output logic                           rd_valid,
  input  logic                           rd_ready,
  output logic [7:0]                     rd_data,
  output logic                           eng_valid,
  output logic [1:0]                     eng_op,
  output logic [7:0]                     eng_wbyte,
  output logic                           eng_last,
  input  logic                           eng_done,
  input  logic                           eng_nack,
  input  logic [7:0]                     eng_rbyte,
  output logic                           busy,
  output logic                           done,
  output logic                           res_present,
  output logic                           res_err,
  output logic [LEN_W-1:0]               res_fails
);
  logic [6:0] dev_eff;
  logic       fail_clr, fail_inc;

  i2cs_dev_fold #(.MAX_ALEN(MAX_ALEN)) u_fold (
    .dev(cmd_dev), .maddr(cmd_maddr), .alen(cmd_alen),
    .mask(cfg_ovf_mask), .dev_eff(dev_eff)
  );

  i2cs_seq #(.MAX_ALEN(MAX_ALEN), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .dev_eff(dev_eff), .cmd_maddr(cmd_maddr), .cmd_alen(cmd_alen),
    .cmd_len(cmd_len), .cfg_rep_start(cfg_rep_start),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .eng_valid(eng_valid), .eng_op(eng_op), .eng_wbyte(eng_wbyte),
    .eng_last(eng_last), .eng_done(eng_done), .eng_nack(eng_nack),
    .eng_rbyte(eng_rbyte), .busy(busy), .done(done),
    .res_present(res_present), .res_err(res_err),
    .fail_clr(fail_clr), .fail_inc(fail_inc)
  );

  i2cs_fail_cnt #(.W(LEN_W)) u_fails (
    .clk(clk), .rst(rst), .clr(fail_clr), .inc(fail_inc), .count(res_fails)
  );
endmodule

// File: rtl/i2c_mem_seq_chk.sv
module i2c_mem_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       done,
  input logic       eng_valid,
  input logic [1:0] eng_op,
  input logic [7:0] eng_wbyte,
  input logic       eng_done,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data
);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R14
  eng_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_valid && !eng_done) |=> (eng_valid && $stable(eng_op) && $stable(eng_wbyte)));
  // R14
  eng_busy_chk: assert property (@(posedge clk) disable iff (rst)
    eng_valid |-> busy);
  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  // R12
  rd_stall_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !eng_valid);
endmodule

bind i2c_mem_seq i2c_mem_seq_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done),
  .eng_valid(eng_valid), .eng_op(eng_op), .eng_wbyte(eng_wbyte),
  .eng_done(eng_done), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_data(rd_data)
);

// File: tb/i2c_mem_seq_bench.sv
`timescale 1ns/1ps
module i2c_mem_seq_bench;
  localparam int MAX_ALEN = 4;
  localparam int LEN_W    = 8;

  logic clk = 1'b0;
  logic rst;
  logic cmd_valid, cmd_ready;
  logic [1:0]  cmd_op;
  logic [6:0]  cmd_dev;
  logic [39:0] cmd_maddr;
  logic [2:0]  cmd_alen;
  logic [7:0]  cmd_len;
  logic cfg_rep_start;
  logic [6:0] cfg_ovf_mask;
  logic wr_valid, wr_ready;
  logic [7:0] wr_data;
  logic rd_valid, rd_ready;
  logic [7:0] rd_data;
  logic eng_valid;
  logic [1:0] eng_op;
  logic [7:0] eng_wbyte;
  logic eng_last, eng_done, eng_nack;
  logic [7:0] eng_rbyte;
  logic busy, done, res_present, res_err;
  logic [7:0] res_fails;

  always #2.5 clk = ~clk;

  i2c_mem_seq #(.MAX_ALEN(MAX_ALEN), .LEN_W(LEN_W)) u_i2c_mem_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_dev(cmd_dev), .cmd_maddr(cmd_maddr),
    .cmd_alen(cmd_alen), .cmd_len(cmd_len), .cfg_rep_start(cfg_rep_start),
    .cfg_ovf_mask(cfg_ovf_mask), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .eng_valid(eng_valid), .eng_op(eng_op),
    .eng_wbyte(eng_wbyte), .eng_last(eng_last), .eng_done(eng_done),
    .eng_nack(eng_nack), .eng_rbyte(eng_rbyte), .busy(busy), .done(done),
    .res_present(res_present), .res_err(res_err), .res_fails(res_fails)
  );

  int total = 0;
  int failed = 0;

  // transaction context shared with the models
  logic [31:0] nmask;
  int wk, rk;
  logic [7:0] rseed;
  logic [10:0] alog [64];
  logic [10:0] elog [64];
  int alog_n, elog_n;
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [64];
  int widx, wlen, rcnt;
  bit wtake;
  bit e_present, e_err;
  int e_fails, e_nr;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", total - failed, total);
  endtask

  function automatic logic [7:0] rgen(input int k);
    return 8'(k * 29 + 92) ^ rseed;
  endfunction

  task automatic epush(input logic [10:0] v);
    if (elog_n < 64) elog[elog_n] = v;
    elog_n++;
  endtask

  // Expected command string and result, from the requirements
  task automatic model(input int op, input logic [6:0] dev, input logic [39:0] maddr,
                       input int alen, input int len, input bit rep,
                       input logic [6:0] mask, input logic [31:0] nm);
    int k;
    logic [6:0] d;
    logic [39:0] sh;
    k = 0; elog_n = 0; e_present = 0; e_err = 0; e_fails = 0; e_nr = 0;
    sh = maddr >> (8 * alen);
    d = dev | (sh[6:0] & mask);
    epush({2'd0, 8'd0, 1'b0});
    if (!(op == 2 && alen == 0)) begin
      epush({2'd2, d, 1'b0, 1'b0});
      if (nm[k]) begin epush({2'd1, 8'd0, 1'b0}); return; end
      k++;
      e_present = 1;
      if (op != 1 && op != 2) begin epush({2'd1, 8'd0, 1'b0}); return; end
      for (int i = alen - 1; i >= 0; i--) begin
        sh = maddr >> (8 * i);
        epush({2'd2, sh[7:0], 1'b0});
        if (nm[k]) begin e_err = 1; epush({2'd1, 8'd0, 1'b0}); return; end
        k++;
      end
      if (op == 1) begin
        for (int j = 0; j < len; j++) begin
          epush({2'd2, wbuf[j], 1'b0});
          if (nm[k]) e_fails++;
          k++;
        end
        epush({2'd1, 8'd0, 1'b0});
        return;
      end
      if (!rep) epush({2'd1, 8'd0, 1'b0});
      epush({2'd0, 8'd0, 1'b0});
    end
    epush({2'd2, d, 1'b1, 1'b0});
    if (nm[k]) begin e_present = 0; epush({2'd1, 8'd0, 1'b0}); return; end
    e_present = 1;
    for (int j = 0; j < len; j++) epush({2'd3, 8'd0, (j == len - 1)});
    e_nr = len;
    epush({2'd1, 8'd0, 1'b0});
  endtask

  // Behavioural byte engine with random latency
  initial begin
    eng_done = 0; eng_nack = 0; eng_rbyte = 0;
    forever begin
      @(negedge clk);
      if (!rst && eng_valid) begin
        logic [1:0] op_s;
        logic [7:0] b_s;
        logic nk;
        op_s = eng_op; b_s = eng_wbyte; nk = 1'b0;
        if (alog_n < 64) begin
          if (op_s == 2'd2) alog[alog_n] = {op_s, b_s, 1'b0};
          else if (op_s == 2'd3) alog[alog_n] = {op_s, 8'd0, eng_last};
          else alog[alog_n] = {op_s, 8'd0, 1'b0};
        end
        alog_n++;
        if (op_s == 2'd2) begin nk = nmask[wk[4:0]]; wk++; end
        if (op_s == 2'd3) begin eng_rbyte = rgen(rk); rk++; end
        repeat ($urandom_range(0, 3)) @(negedge clk);
        if (eng_op != op_s || (op_s == 2'd2 && eng_wbyte != b_s) || !eng_valid)
          chk(0, "R14 command held until done", {eng_valid, eng_op, eng_wbyte}, {1'b1, op_s, b_s});
        eng_done = 1; eng_nack = nk;
        @(negedge clk);
        eng_done = 0; eng_nack = 0;
      end
    end
  end

  // Write data source with random gaps
  initial begin
    wr_valid = 0; wr_data = 0; wtake = 0; widx = 0; wlen = 0;
    forever begin
      @(negedge clk);
      if (wtake) widx++;
      wtake = 0;
      if (widx < wlen && $urandom_range(0, 3) != 0) begin
        wr_valid = 1; wr_data = wbuf[widx];
      end else wr_valid = 0;
      #1;
      wtake = wr_valid && wr_ready;
    end
  end

  // Read data consumer with random stalls
  initial begin
    rd_ready = 0; rcnt = 0;
    forever begin
      @(negedge clk);
      rd_ready = ($urandom_range(0, 3) != 0);
      #1;
      if (!rst && rd_valid && rd_ready) begin
        if (rcnt < 64) rbuf[rcnt] = rd_data;
        rcnt++;
      end
    end
  end

  task automatic run(input int op, input logic [6:0] dev, input logic [39:0] maddr,
                     input int alen, input int len, input bit rep,
                     input logic [6:0] mask, input logic [31:0] nm, input string tag);
    int cyc;
    bit seq_ok;
    nmask = nm; wk = 0; rk = 0; alog_n = 0; rcnt = 0;
    for (int j = 0; j < 16; j++) wbuf[j] = 8'($urandom);
    rseed = 8'($urandom);
    widx = 0;
    wlen = (op == 1) ? len : 0;
    model(op, dev, maddr, alen, len, rep, mask, nm);
    @(negedge clk);
    chk(cmd_ready == 1'b1, {tag, " R11 ready when idle"}, cmd_ready, 1);
    cmd_valid = 1; cmd_op = 2'(op); cmd_dev = dev; cmd_maddr = maddr;
    cmd_alen = 3'(alen); cmd_len = 8'(len); cfg_rep_start = rep; cfg_ovf_mask = mask;
    @(negedge clk);
    cmd_valid = 0;
    chk(busy && !cmd_ready, {tag, " R11 busy after accept"}, {busy, cmd_ready}, 2'b10);
    cyc = 0;
    while (!done && cyc < 4000) begin @(negedge clk); cyc++; end
    chk(done && !busy, {tag, " R11 done with busy low"}, {done, busy}, 2'b10);
    chk(res_present == e_present, {tag, " present"}, res_present, e_present);
    chk(res_err == e_err, {tag, " R5 error flag"}, res_err, e_err);
    chk(int'(res_fails) == e_fails, {tag, " R9 fail count"}, res_fails, e_fails);
    seq_ok = (alog_n == elog_n);
    for (int i = 0; i < elog_n && i < 64; i++)
      if (seq_ok && alog[i] != elog[i]) begin
        seq_ok = 0;
        $display("FAIL %s R1 command %0d: actual %0h expected %0h", tag, i, alog[i], elog[i]);
      end
    if (!seq_ok && alog_n != elog_n)
      $display("FAIL %s R1 command count: actual %0d expected %0d", tag, alog_n, elog_n);
    total++;
    if (!seq_ok) failed++;
    if (op == 2) begin
      bit d_ok;
      d_ok = (rcnt == e_nr);
      for (int j = 0; j < e_nr && j < 64; j++)
        if (d_ok && rbuf[j] != rgen(j)) begin
          d_ok = 0;
          $display("FAIL %s R12 read byte %0d: actual %0h expected %0h", tag, j, rbuf[j], rgen(j));
        end
      if (!d_ok && rcnt != e_nr)
        $display("FAIL %s R12 read count: actual %0d expected %0d", tag, rcnt, e_nr);
      total++;
      if (!d_ok) failed++;
    end
    if (op == 1) begin
      int exp_taken;
      exp_taken = (e_present && !e_err) ? len : 0;
      chk(widx == exp_taken, {tag, " R13 write bytes taken"}, widx, exp_taken);
    end
    @(negedge clk);
    chk(!done, {tag, " R11 done single cycle"}, done, 0);
    wlen = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; failed++;
    $display("FAIL R11 watchdog: actual hung expected finished");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1; cmd_valid = 0; cmd_op = 0; cmd_dev = 0; cmd_maddr = 0;
    cmd_alen = 0; cmd_len = 0; cfg_rep_start = 0; cfg_ovf_mask = 0;
    nmask = 0; wk = 0; rk = 0; alog_n = 0; rseed = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!busy && cmd_ready && !done && !eng_valid && !rd_valid,
        "R11 reset state", {busy, cmd_ready, done, eng_valid, rd_valid}, 5'b01000);

    run(0, 7'h50, 40'h0, 0, 0, 0, 7'h0, 32'h0, "R2 probe ack");
    run(0, 7'h2B, 40'h0, 0, 0, 0, 7'h0, 32'h1, "R2 probe nack");
    run(3, 7'h11, 40'h0, 0, 0, 0, 7'h0, 32'h0, "R2 code 3 as probe");
    run(1, 7'h50, 40'h1234, 2, 4, 0, 7'h0, 32'b101000, "R9 write data nacks");
    run(1, 7'h51, 40'hA1B2C3D4, 4, 1, 0, 7'h0, 32'h0, "R3 four address bytes");
    run(1, 7'h52, 40'h0, 0, 0, 0, 7'h0, 32'h0, "R3 no address no data");
    run(1, 7'h53, 40'h77, 1, 3, 0, 7'h0, 32'h1, "R4 write no device");
    run(2, 7'h54, 40'h0102, 2, 3, 0, 7'h0, 32'h0, "R6 stop then start");
    run(2, 7'h55, 40'h0304, 2, 3, 1, 7'h0, 32'h0, "R6 repeated start");
    run(2, 7'h56, 40'h0, 0, 2, 0, 7'h0, 32'h0, "R7 no pointer write");
    run(2, 7'h57, 40'h10, 1, 2, 0, 7'h0, 32'h1, "R4 read no device");
    run(2, 7'h58, 40'h0506, 2, 2, 0, 7'h0, 32'b100, "R5 address nack");
    run(2, 7'h59, 40'h0A, 1, 1, 0, 7'h0, 32'h0, "R8 single read byte");
    run(2, 7'h5A, 40'h0B, 1, 0, 1, 7'h0, 32'h0, "R8 zero length read");
    run(2, 7'h5B, 40'h0, 0, 3, 0, 7'h0, 32'h1, "R8 read address nack");
    run(1, 7'h50, 40'h3A5, 1, 2, 0, 7'h07, 32'h0, "R10 fold overflow");
    run(1, 7'h50, 40'h3A5, 1, 2, 0, 7'h00, 32'h0, "R10 zero mask");
    run(2, 7'h40, 40'h15_DEADBEEF, 4, 2, 1, 7'h7F, 32'h0, "R10 fold above four bytes");
    run(2, 7'h41, 40'h0, 0, 16, 0, 7'h0, 32'h0, "R12 long read stalls");
    run(1, 7'h42, 40'h99, 1, 16, 0, 7'h0, 32'h0, "R13 long write");

    for (int t = 0; t < 40; t++) begin
      int op, alen, len;
      logic [6:0] mask;
      op = $urandom_range(0, 2);
      alen = $urandom_range(0, 4);
      len = $urandom_range(0, 8);
      mask = ($urandom_range(0, 1) != 0) ? 7'($urandom) : 7'h0;
      run(op, 7'($urandom), {8'($urandom), 32'($urandom)}, alen, len,
          1'($urandom), mask, $urandom & $urandom & $urandom, "R3 random");
    end

    report();
    $finish;
  end
endmodule